// File: doc/BRIEF.md
# Floating-Point Register Block Transfer Sequencer

This block turns one "move several floating-point registers" request into a series of 64-bit memory beats. A start handshake delivers a 16-bit extension word and a 32-bit base address. The block first checks the extension word. If the word is valid, the block walks the 8-bit register-select mask in the word. For each selected register it issues one memory request that carries an address, a direction and a register index. It then holds that request until the memory side acknowledges it.

The mask is walked from its most significant bit down. Mask bit 7 selects F0, and mask bit 0 selects F7. Clear mask bits cost no cycle. After an acknowledged beat, the next selected register is requested in the very next cycle. The address starts at the base and grows by 8 bytes only between two beats, so the last beat is never followed by an increment. A one-cycle done pulse ends a normal sequence. A fault input aborts the sequence and gives a one-cycle fault pulse in place of done. An invalid extension word gives a one-cycle illegal pulse, and no sequence starts.

Top module: `fp_xfer_seq`

## Requirements
- R1: A start taken while idle is valid only when extension bits 12:8 equal 5'b10000 and bits 7:0 are not all zero. Otherwise `illegal_o` pulses high for one cycle, in the cycle after start, and no request is issued.
- R2: Beats are issued in mask order from bit 7 down to bit 0. Mask bit b gives `req_reg_o` = 7 - b, so bit 7 is F0 and bit 0 is F7.
- R3: `req_store_o` equals extension bit 13 for every beat of the sequence: 1 means store, register to memory, and 0 means load.
- R4: The k-th beat (counting from 0) uses address base + 8*k. The first beat uses the base unchanged.
- R5: The first request appears in the cycle after an accepted start. After an acknowledged beat that is not the last, the next selected register is requested in the following cycle. Clear mask bits add no cycles.
- R6: While `req_o` is high and `ack_i` is low, the address, register index and direction stay stable.
- R7: `done_o` pulses for exactly one cycle, in the cycle after the acknowledge of the last beat, with `req_o` low. `busy_o` is high from the cycle after an accepted start until that point.
- R8: A start that arrives while a sequence is running is ignored. The running beats are unchanged, and no new sequence follows the done pulse.
- R9: `fault_i` sampled high during a beat ends the sequence. In the next cycle `fault_o` pulses for one cycle, `req_o` is low, and `done_o` stays low. Fault takes priority over an acknowledge in the same cycle.
- R10: After reset, `req_o`, `busy_o`, `done_o`, `fault_o` and `illegal_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only while idle |
| ext_i | input | 16 | Extension word: bits 7:0 mask, bits 12:8 check field, bit 13 direction |
| base_i | input | 32 | Base byte address, sampled at start |
| busy_o | output | 1 | Sequence in progress |
| req_o | output | 1 | Memory request valid |
| req_addr_o | output | 32 | Beat address |
| req_store_o | output | 1 | 1 for store, 0 for load |
| req_reg_o | output | 3 | Floating-point register index of the beat |
| ack_i | input | 1 | Beat acknowledge |
| fault_i | input | 1 | Abort the running sequence |
| done_o | output | 1 | One-cycle pulse when a sequence completes |
| fault_o | output | 1 | One-cycle pulse when a sequence is aborted |
| illegal_o | output | 1 | One-cycle pulse for a rejected extension word |

## Verification
The hardest case to reach from the ports is a start that arrives in the middle of a sequence while a beat is still waiting. The bench raises `start_i` with a different valid word during the first beat. It then checks every remaining beat, and the single done pulse, against the original word.

Sparse masks are the other hard case, because there the zero-cycle skip and the absence of a final increment show. The bench drives random masks, in both directions, with random acknowledge delays. It compares every beat with the model address base + 8*k. It also aims faults at chosen beat numbers, including a fault in the same cycle as an acknowledge.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned MASK_W   = 8;
  localparam int unsigned EXT_W    = 16;
  localparam int unsigned CHK_LSB  = 8;
  localparam int unsigned CHK_W    = 5;
  localparam logic [4:0]  CHK_VAL  = 5'b10000;
  localparam int unsigned DIR_BIT  = 13;
endpackage

// File: rtl/fpx_decode.sv
module fpx_decode
  import fpx_pkg::*;
(
  input  logic [EXT_W-1:0]  ext_i,
  output logic              valid_o,
  output logic              store_o,
  output logic [MASK_W-1:0] mask_o
);
  assign mask_o  = ext_i[MASK_W-1:0];
  assign store_o = ext_i[DIR_BIT];
  assign valid_o = (ext_i[CHK_LSB +: CHK_W] == CHK_VAL) && (|mask_o);
endmodule

// File: rtl/fpx_pick.sv
module fpx_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  rest_o
);
  // highest set bit wins; register index counts up from the top bit
  always_comb begin
    idx_o  = '0;
    rest_o = mask_i;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i]) begin
        idx_o  = IW'(N - 1 - i);
        rest_o = mask_i & ~(N'(1) << i);
      end
    end
  end
endmodule

// File: rtl/fpx_addr.sv
module fpx_addr #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= base_i;
    else if (step_i) addr_o <= addr_o + AW'(STEP);
  end
endmodule

// File: rtl/fp_xfer_seq.sv
module fp_xfer_seq
  import fpx_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 8,
  localparam int unsigned IW  = $clog2(MASK_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [EXT_W-1:0] ext_i,
  input  logic [AW-1:0]    base_i,
  output logic             busy_o,
  output logic             req_o,
  output logic [AW-1:0]    req_addr_o,
  output logic             req_store_o,
  output logic [IW-1:0]    req_reg_o,
  input  logic             ack_i,
  input  logic             fault_i,
  output logic             done_o,
  output logic             fault_o,
  output logic             illegal_o
);
  logic              dec_valid, dec_store;
  logic [MASK_W-1:0] dec_mask, mask_q, rest;
  logic              busy_q, store_q, done_q, fault_q, illegal_q;
  logic              launch, step;

  fpx_decode u_dec (
    .ext_i  (ext_i),
    .valid_o(dec_valid),
    .store_o(dec_store),
    .mask_o (dec_mask)
  );

  fpx_pick #(.N(MASK_W)) u_pick (
    .mask_i(mask_q),
    .idx_o (req_reg_o),
    .rest_o(rest)
  );

  assign launch = start_i && !busy_q && dec_valid;
  // advance only when lower mask bits are still pending
  assign step   = busy_q && ack_i && !fault_i && (|rest);

  fpx_addr #(.AW(AW), .STEP(STEP)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(launch),
    .base_i(base_i),
    .step_i(step),
    .addr_o(req_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      mask_q    <= '0;
      store_q   <= 1'b0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      illegal_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          if (dec_valid) begin
            busy_q  <= 1'b1;
            mask_q  <= dec_mask;
            store_q <= dec_store;
          end else begin
            illegal_q <= 1'b1;
          end
        end
      end else if (fault_i) begin
        busy_q  <= 1'b0;
        mask_q  <= '0;
        fault_q <= 1'b1;
      end else if (ack_i) begin
        mask_q <= rest;
        if (rest == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign req_o       = busy_q;
  assign req_store_o = store_q;
  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign illegal_o   = illegal_q;
endmodule

// File: rtl/fp_xfer_seq_chk.sv
module fp_xfer_seq_chk #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          req_o,
  input logic [AW-1:0] req_addr_o,
  input logic          req_store_o,
  input logic [2:0]    req_reg_o,
  input logic          ack_i,
  input logic          fault_i,
  input logic          done_o,
  input logic          fault_o,
  input logic          illegal_o
);
  AST_HOLD_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i && !fault_i |=> req_o && $stable(req_addr_o) && $stable(req_reg_o) && $stable(req_store_o)); // R6

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && !fault_i |=> done_o || (req_o && req_addr_o == $past(req_addr_o) + AW'(STEP))); // R4

  AST_REG_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && !fault_i |=> done_o || (req_o && req_reg_o > $past(req_reg_o))); // R2

  AST_DIR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && !fault_i |=> done_o || $stable(req_store_o)); // R3

  AST_FAULT_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && fault_i |=> fault_o && !req_o && !done_o); // R9

  AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, fault_o, illegal_o})); // R7

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o && !busy_o); // R7

  AST_ILLEGAL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !req_o); // R1
endmodule

bind fp_xfer_seq fp_xfer_seq_chk #(.AW(AW), .STEP(STEP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .req_o      (req_o),
  .req_addr_o (req_addr_o),
  .req_store_o(req_store_o),
  .req_reg_o  (req_reg_o),
  .ack_i      (ack_i),
  .fault_i    (fault_i),
  .done_o     (done_o),
  .fault_o    (fault_o),
  .illegal_o  (illegal_o)
);

// File: tb/fp_xfer_seq_test.sv
module fp_xfer_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] ext_i = '0;
  logic [31:0] base_i = '0;
  logic        busy_o, req_o, req_store_o, done_o, fault_o, illegal_o;
  logic [31:0] req_addr_o;
  logic [2:0]  req_reg_o;
  logic        ack_i = 1'b0;
  logic        fault_i = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  fp_xfer_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ext_i(ext_i), .base_i(base_i),
    .busy_o(busy_o), .req_o(req_o), .req_addr_o(req_addr_o), .req_store_o(req_store_o),
    .req_reg_o(req_reg_o), .ack_i(ack_i), .fault_i(fault_i), .done_o(done_o),
    .fault_o(fault_o), .illegal_o(illegal_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_ext(input bit st, input logic [7:0] m);
    return {2'b00, st, 5'b10000, m};
  endfunction

  // fault_at: beat number that is hit by a fault (-1 for none)
  task automatic run_seq(input logic [15:0] ext, input logic [31:0] base,
                         input bit poke, input int fault_at);
    int q[$];
    int k = 0;
    int waits = 0;
    bit a;
    for (int b = 7; b >= 0; b--) if (ext[b]) q.push_back(7 - b);
    @(negedge clk_i);
    start_i = 1'b1; ext_i = ext; base_i = base;
    @(negedge clk_i);
    start_i = 1'b0; ext_i = 16'h0000; base_i = 32'hdead_beef;
    while (q.size() > 0) begin
      chk(req_o == 1'b1 && busy_o == 1'b1, "R5 request present", {31'b0, req_o}, 1);
      chk(req_reg_o == 3'(q[0]), "R2 register index", {29'b0, req_reg_o}, 32'(q[0]));
      chk(req_addr_o == base + 32'(8 * k), "R4 beat address", req_addr_o, base + 32'(8 * k));
      chk(req_store_o == ext[13], "R3 direction", {31'b0, req_store_o}, {31'b0, ext[13]});
      chk(done_o == 1'b0, "R7 no early done", {31'b0, done_o}, 0);
      if (fault_at == k) begin
        fault_i = 1'b1; ack_i = 1'b1;
        @(negedge clk_i);
        fault_i = 1'b0; ack_i = 1'b0;
        chk(fault_o == 1'b1, "R9 fault pulse", {31'b0, fault_o}, 1);
        chk(done_o == 1'b0 && req_o == 1'b0, "R9 aborted", {30'b0, done_o, req_o}, 0);
        @(negedge clk_i);
        chk(fault_o == 1'b0 && req_o == 1'b0, "R9 fault single cycle", {30'b0, fault_o, req_o}, 0);
        return;
      end
      a = (waits >= 2) || ($urandom % 2 == 1);
      if (poke && k == 0 && waits == 0) begin
        start_i = 1'b1; ext_i = mk_ext(~ext[13], 8'h5a); base_i = 32'h0000_1000;
      end
      ack_i = a;
      @(negedge clk_i);
      ack_i = 1'b0; start_i = 1'b0;
      if (a) begin
        void'(q.pop_front());
        k++; waits = 0;
      end else begin
        waits++;
      end
    end
    chk(done_o == 1'b1, "R7 done pulse", {31'b0, done_o}, 1);
    chk(req_o == 1'b0 && busy_o == 1'b0, "R7 idle at done", {30'b0, req_o, busy_o}, 0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7 done single cycle", {31'b0, done_o}, 0);
    chk(req_o == 1'b0, poke ? "R8 no queued start" : "R7 stays idle", {31'b0, req_o}, 0);
  endtask

  task automatic try_bad(input logic [15:0] ext);
    @(negedge clk_i);
    start_i = 1'b1; ext_i = ext; base_i = 32'h40;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(illegal_o == 1'b1, "R1 illegal pulse", {31'b0, illegal_o}, 1);
    chk(req_o == 1'b0 && busy_o == 1'b0, "R1 no start", {30'b0, req_o, busy_o}, 0);
    @(negedge clk_i);
    chk(illegal_o == 1'b0 && req_o == 1'b0, "R1 pulse ends", {30'b0, illegal_o, req_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk({req_o, busy_o, done_o, fault_o, illegal_o} == 5'b0, "R10 reset state",
        {27'b0, req_o, busy_o, done_o, fault_o, illegal_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_o == 1'b0, "R10 idle after reset", {31'b0, req_o}, 0);

    try_bad(mk_ext(1'b0, 8'h00));           // R1 empty mask
    try_bad({2'b00, 1'b1, 5'b10001, 8'h81}); // R1 bad check field
    try_bad({2'b00, 1'b0, 5'b00000, 8'hff}); // R1 bad check field

    run_seq(mk_ext(1'b0, 8'h80), 32'h0000_0100, 1'b0, -1); // F0 only, R2
    run_seq(mk_ext(1'b1, 8'h01), 32'h0000_0200, 1'b0, -1); // F7 only, R4 no step
    run_seq(mk_ext(1'b1, 8'hff), 32'hffff_fff0, 1'b0, -1); // all, wraps
    run_seq(mk_ext(1'b0, 8'h81), 32'h0000_0300, 1'b0, -1); // R5 sparse
    run_seq({2'b11, 1'b0, 5'b10000, 8'h3c}, 32'h10, 1'b0, -1); // bits 15:14 ignored

    run_seq(mk_ext(1'b0, 8'hc3), 32'h0000_0400, 1'b1, -1); // R8
    run_seq(mk_ext(1'b1, 8'h24), 32'h0000_0500, 1'b1, -1); // R8

    run_seq(mk_ext(1'b1, 8'hf0), 32'h0000_0600, 1'b0, 0); // R9 first beat
    run_seq(mk_ext(1'b0, 8'h0f), 32'h0000_0700, 1'b0, 2); // R9 mid
    run_seq(mk_ext(1'b0, 8'h44), 32'h0000_0800, 1'b0, 1); // R9 last beat with ack

    for (int n = 0; n < 60; n++) begin
      logic [7:0] m;
      m = 8'($urandom);
      if (m == 8'h00) m = 8'h10;
      run_seq(mk_ext(1'($urandom), m), {$urandom} & 32'hffff_fff8, 1'($urandom % 4 == 0), -1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule